// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block takes a 32-bit IEEE-754 single-precision word and produces the 16-bit half-precision word nearest to it, rounding to nearest with ties to even. The value is sorted into one of four classes: NaN, too large, inside the half-precision normal range, or too small. Each class has its own datapath, and a final multiplexer picks the result and attaches the sign.

Values that fall below the half-precision normal range are denormalized with a sticky bit, so that bits shifted out still count in the rounding decision. A NaN stays a NaN: the quiet bit is always set and the upper payload bits are kept. By default the result is captured in an output register that loads only on cycles where the input is marked valid. The output valid flag is that marker delayed by one cycle.

Top module: `fp_narrow_s2h`

## Requirements
- R1: Output bit 15 always equals input bit 31, in every class.
- R2: For an input biased exponent E in 113..142, the output exponent field (bits 14:10) is E-112. The output mantissa (bits 9:0) is input bits 22:13 when input bits 12:0 are zero.
- R3: In the normal range, the 13 discarded bits (12:0) round the result up by one when they exceed 0x1000 and leave it unchanged when below. At exactly 0x1000 the result goes up only when its own bit 0 is 1.
- R4: A rounding increment that overflows the 10-bit mantissa carries into the exponent. At E=142 this gives infinity (0x7C00). At E=112 a subnormal that rounds up gives 0x0400.
- R5: A non-NaN input with biased exponent 143 or above, including infinity, gives magnitude 0x7C00.
- R6: A NaN input (exponent 255, mantissa non-zero) gives exponent 0x1F, bit 9 set, and bits 8:0 equal to input bits 21:13.
- R7: For E in 90..112 the output is the subnormal (or zero, or 0x0400) nearest to the exact input value. Ties go to even, and a set bit anywhere below the halfway point counts as above the tie.
- R8: Inputs with E below 90, including zeros and single-precision subnormals, give a signed zero (0x0000 or 0x8000).
- R9: After reset the output word and valid flag are zero. The output word loads the converted value on the clock edge where in_valid_i is high and holds otherwise. out_valid_o is in_valid_i delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input word is valid this cycle |
| in_word_i | input | 32 | Single-precision input |
| out_valid_o | output | 1 | Output word holds a fresh result |
| out_word_o | output | 16 | Half-precision result |

## Verification
Assertions check on every cycle the properties that can be read straight from the input fields:
- sign pass-through;
- the NaN exponent and quiet bit;
- the infinity result for oversized inputs;
- a non-zero exponent for normal-range inputs;
- zero for very small inputs;
- the load and hold behaviour of the output register and its valid flag.

The exact rounded values need the bench's arithmetic model. This covers tie-to-even decisions, sticky rounding in the subnormal path, carries into the exponent and the truncated NaN payload. The model is driven by sweeps over every exponent with edge and tie mantissas.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
  typedef enum logic [1:0] {
    CLS_UNDER  = 2'd0,
    CLS_NORMAL = 2'd1,
    CLS_OVER   = 2'd2,
    CLS_NAN    = 2'd3
  } fpn_class_e;
endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
  import fpn_pkg::*;
#(
  parameter int SRC_EXP_W = 8,
  parameter int SRC_MAN_W = 23,
  parameter int UND_EXP   = 113,
  parameter int OVF_EXP   = 143
) (
  input  logic [SRC_EXP_W-1:0] exp_i,
  input  logic [SRC_MAN_W-1:0] man_i,
  output fpn_class_e           cls_o
);
  always_comb begin
    if ((&exp_i) && (|man_i)) begin
      cls_o = CLS_NAN;
    end else if (exp_i >= SRC_EXP_W'(OVF_EXP)) begin
      cls_o = CLS_OVER;
    end else if (exp_i >= SRC_EXP_W'(UND_EXP)) begin
      cls_o = CLS_NORMAL;
    end else begin
      cls_o = CLS_UNDER;
    end
  end
endmodule

// File: rtl/fpn_rne.sv
module fpn_rne #(
  parameter int KEEP_W = 15,
  parameter int DROP_W = 13
) (
  input  logic [KEEP_W-1:0] base_i,
  input  logic [DROP_W-1:0] rest_i,
  output logic [KEEP_W-1:0] rounded_o
);
  localparam logic [DROP_W-1:0] HALF = DROP_W'(1) << (DROP_W - 1);

  logic inc;

  always_comb begin
    inc       = (rest_i > HALF) || ((rest_i == HALF) && base_i[0]);
    rounded_o = base_i + KEEP_W'(inc);
  end
endmodule

// File: rtl/fpn_norm_path.sv
module fpn_norm_path #(
  parameter int DST_EXP_W = 5,
  parameter int DST_MAN_W = 10,
  parameter int DROP_W    = 13,
  parameter int BIAS_DIFF = 112
) (
  input  logic [DST_EXP_W+DST_MAN_W-1:0] kept_i,
  input  logic [DROP_W-1:0]              rest_i,
  output logic [DST_EXP_W+DST_MAN_W-1:0] res_o
);
  localparam int RW = DST_EXP_W + DST_MAN_W;
  localparam logic [RW-1:0] BIAS_OFF = RW'(BIAS_DIFF) << DST_MAN_W;

  logic [RW-1:0] rebased;

  // modular subtraction: only the low RW bits of the rebiased value matter
  always_comb rebased = kept_i - BIAS_OFF;

  fpn_rne #(.KEEP_W(RW), .DROP_W(DROP_W)) u_rne (
    .base_i   (rebased),
    .rest_i   (rest_i),
    .rounded_o(res_o)
  );
endmodule

// File: rtl/fpn_sub_path.sv
module fpn_sub_path #(
  parameter int SRC_EXP_W = 8,
  parameter int SRC_MAN_W = 23,
  parameter int DST_MAN_W = 10,
  parameter int UND_EXP   = 113
) (
  input  logic [SRC_EXP_W-1:0] exp_i,
  input  logic [SRC_MAN_W-1:0] man_i,
  output logic [DST_MAN_W:0]   res_o
);
  localparam int SIG_W  = SRC_MAN_W + 1;
  localparam int SHW    = SRC_EXP_W + 1;
  localparam int DROP_W = SRC_MAN_W - DST_MAN_W;

  logic [SHW-1:0]   shamt;
  logic             too_far;
  logic [SIG_W-1:0] sig;
  logic [SIG_W-1:0] lost_mask;
  logic             sticky;
  logic [SIG_W-1:0] denorm;
  logic [DST_MAN_W:0] rounded;

  always_comb begin
    shamt     = SHW'(UND_EXP) - {1'b0, exp_i};
    too_far   = shamt > SHW'(SRC_MAN_W);
    sig       = {1'b1, man_i};
    lost_mask = ~({SIG_W{1'b1}} << shamt);
    sticky    = |(sig & lost_mask);
    denorm    = (sig >> shamt) | SIG_W'(sticky);
  end

  fpn_rne #(.KEEP_W(DST_MAN_W + 1), .DROP_W(DROP_W)) u_rne (
    .base_i   (denorm[SIG_W-1:DROP_W]),
    .rest_i   (denorm[DROP_W-1:0]),
    .rounded_o(rounded)
  );

  always_comb res_o = too_far ? '0 : rounded;
endmodule

// File: rtl/fp_narrow_s2h.sv
module fp_narrow_s2h
  import fpn_pkg::*;
#(
  parameter int SRC_EXP_W = 8,
  parameter int SRC_MAN_W = 23,
  parameter int DST_EXP_W = 5,
  parameter int DST_MAN_W = 10,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 in_valid_i,
  input  logic [SRC_EXP_W+SRC_MAN_W:0]         in_word_i,
  output logic                                 out_valid_o,
  output logic [DST_EXP_W+DST_MAN_W:0]         out_word_o
);
  localparam int SW        = 1 + SRC_EXP_W + SRC_MAN_W;
  localparam int DW        = 1 + DST_EXP_W + DST_MAN_W;
  localparam int RW        = DW - 1;
  localparam int SRC_BIAS  = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int DST_BIAS  = (1 << (DST_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF = SRC_BIAS - DST_BIAS;
  localparam int DROP_W    = SRC_MAN_W - DST_MAN_W;
  localparam int UND_EXP   = BIAS_DIFF + 1;
  localparam int OVF_EXP   = BIAS_DIFF + (1 << DST_EXP_W) - 1;
  localparam int ZERO_EXP  = UND_EXP - SRC_MAN_W;
  localparam logic [RW-1:0] INF_MAG = {{DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};

  logic                 in_sign;
  logic [SRC_EXP_W-1:0] in_exp;
  logic [SRC_MAN_W-1:0] in_man;
  fpn_class_e           cls;
  logic [RW-1:0]        norm_res;
  logic [DST_MAN_W:0]   sub_res;
  logic [RW-1:0]        mag_res;
  logic [DW-1:0]        result;

  always_comb begin
    in_sign = in_word_i[SW-1];
    in_exp  = in_word_i[SW-2:SRC_MAN_W];
    in_man  = in_word_i[SRC_MAN_W-1:0];
  end

  fpn_classify #(
    .SRC_EXP_W(SRC_EXP_W), .SRC_MAN_W(SRC_MAN_W),
    .UND_EXP(UND_EXP), .OVF_EXP(OVF_EXP)
  ) u_cls (
    .exp_i(in_exp), .man_i(in_man), .cls_o(cls)
  );

  fpn_norm_path #(
    .DST_EXP_W(DST_EXP_W), .DST_MAN_W(DST_MAN_W),
    .DROP_W(DROP_W), .BIAS_DIFF(BIAS_DIFF)
  ) u_norm (
    .kept_i(in_word_i[DROP_W+RW-1:DROP_W]),
    .rest_i(in_word_i[DROP_W-1:0]),
    .res_o (norm_res)
  );

  fpn_sub_path #(
    .SRC_EXP_W(SRC_EXP_W), .SRC_MAN_W(SRC_MAN_W),
    .DST_MAN_W(DST_MAN_W), .UND_EXP(UND_EXP)
  ) u_sub (
    .exp_i(in_exp), .man_i(in_man), .res_o(sub_res)
  );

  always_comb begin
    unique case (cls)
      CLS_NAN:    mag_res = {{DST_EXP_W{1'b1}}, 1'b1, in_man[SRC_MAN_W-2:DROP_W]};
      CLS_OVER:   mag_res = INF_MAG;
      CLS_NORMAL: mag_res = norm_res;
      default:    mag_res = RW'(sub_res);
    endcase
    result = {in_sign, mag_res};
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [DW-1:0] word_d, word_q;
      logic          vld_q;

      always_comb word_d = in_valid_i ? result : word_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          word_q <= '0;
          vld_q  <= 1'b0;
        end else begin
          word_q <= word_d;
          vld_q  <= in_valid_i;
        end
      end

      always_comb begin
        out_word_o  = word_q;
        out_valid_o = vld_q;
      end

      AST_SIGN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_word_o[DW-1] == $past(in_word_i[SW-1])); // R1
      AST_NORM_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && in_exp >= SRC_EXP_W'(UND_EXP) && in_exp < SRC_EXP_W'(OVF_EXP)
        |=> out_word_o[DW-2:DST_MAN_W] != '0); // R2
      AST_OVF_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && in_exp >= SRC_EXP_W'(OVF_EXP) && !((&in_exp) && (|in_man))
        |=> out_word_o[DW-2:0] == INF_MAG); // R5
      AST_NAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && (&in_exp) && (|in_man)
        |=> (&out_word_o[DW-2:DST_MAN_W]) && out_word_o[DST_MAN_W-1]); // R6
      AST_TINY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && in_exp < SRC_EXP_W'(ZERO_EXP) |=> out_word_o[DW-2:0] == '0); // R8
      AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> $stable(out_word_o)); // R9
      AST_VALID_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o); // R9
      AST_VALID_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o); // R9
    end else begin : g_comb
      always_comb begin
        out_word_o  = result;
        out_valid_o = in_valid_i;
      end
    end
  endgenerate
endmodule

// File: tb/fp_narrow_s2h_tb_top.sv
`timescale 1ns/1ps
module fp_narrow_s2h_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        out_valid;
  logic [15:0] out_word;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  fp_narrow_s2h dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_word_i(in_word),
    .out_valid_o(out_valid), .out_word_o(out_word)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Arithmetic model: exact integer rounding on the full remainder.
  function automatic logic [15:0] ref_h(input logic [31:0] x);
    logic s;
    int   e;
    longint sig, q, r, h, mag;
    int   d;
    s = x[31];
    e = int'(x[30:23]);
    if (e == 255) begin
      if (x[22:0] != 0) return {s, 5'h1F, 1'b1, x[21:13]};
      return {s, 15'h7C00};
    end
    if (e == 0) return {s, 15'h0000};
    if (e >= 143) return {s, 15'h7C00};
    sig = (64'd1 << 23) | longint'(x[22:0]);
    d = (e >= 113) ? 13 : 126 - e;
    if (d >= 26) return {s, 15'h0000};
    q = sig >> d;
    r = sig & ((64'd1 << d) - 1);
    h = 64'd1 << (d - 1);
    if (r > h || (r == h && q[0])) q = q + 1;
    if (e >= 113) mag = (longint'(e - 112) << 10) + q - 1024;
    else mag = q;
    return {s, mag[14:0]};
  endfunction

  function automatic string tag_of(input logic [31:0] x);
    int e;
    e = int'(x[30:23]);
    if (e == 255 && x[22:0] != 0) return "R6";
    if (e >= 143) return "R5";
    if (e < 90) return "R8";
    if (e < 113) return "R7";
    if (x[12:0] != 0) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input string tag);
    logic [15:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    e = ref_h(w);
    @(negedge clk);
    check(tag, {16'h0, out_word}, {16'h0, e}, $sformatf("in=%h", w));
    check("R1", {31'h0, out_word[15]}, {31'h0, w[31]}, $sformatf("sign in=%h", w));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = 32'h0;
    repeat (3) @(negedge clk);
    check("R9", {16'h0, out_word}, 32'h0, "reset word");
    check("R9", {31'h0, out_valid}, 32'h0, "reset valid");
    rst_n = 1'b1;

    // Directed corner cases
    apply(32'h3F800000, "R2");   // 1.0 -> 0x3C00
    apply(32'h477FF000, "R4");   // rounds to infinity
    apply(32'h387FF000, "R4");   // top subnormal rounds to 0x0400
    apply(32'h3F801000, "R3");   // tie, even -> stays
    apply(32'h3F803000, "R3");   // tie, odd -> up
    apply(32'h33000000, "R7");   // exact half of min subnormal -> 0
    apply(32'h33000001, "R7");   // sticky pushes to 1
    apply(32'h7FC00000, "R6");
    apply(32'h7F800001, "R6");
    apply(32'hFFFFFFFF, "R6");
    apply(32'hFF800000, "R5");
    apply(32'h7F7FFFFF, "R5");
    apply(32'h00000001, "R8");
    apply(32'h80000000, "R8");
    apply(32'h00000000, "R8");
    check("R9", {31'h0, out_valid}, 32'h1, "valid after load");

    // Hold: deassert valid with a different word
    held = out_word;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 32'h3F800000;
    @(negedge clk);
    check("R9", {16'h0, out_word}, {16'h0, held}, "hold word");
    check("R9", {31'h0, out_valid}, 32'h0, "valid drop");

    // Sweep every exponent, both signs, edge and tie mantissas
    for (int e = 0; e < 256; e++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 8; p++) begin
          logic [22:0] m;
          logic [31:0] r;
          r = $urandom;
          case (p)
            0: m = 23'h0;
            1: m = 23'h7FFFFF;
            2: m = (r[22:0] & 23'h7FC000) | 23'h1000;
            3: m = (r[22:0] & 23'h7FC000) | 23'h3000;
            4: m = (r[22:0] & 23'h7FE000) | 23'h1001;
            5: m = (r[22:0] & 23'h7FE000) | 23'h0FFF;
            default: m = r[22:0];
          endcase
          apply({s[0], e[7:0], m}, tag_of({s[0], e[7:0], m}));
        end
      end
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule